// File: doc/BRIEF.md
# Two-Channel DMA Engine

This block is a direct memory access engine with two independent channels that copy data from a source address to a destination address over a simple single-master memory bus. Each channel is armed with its own source address, destination address, unit count, unit width, transfer mode and trigger selection. Once armed, a channel waits for a trigger. The trigger is either a one-cycle software request pulse or a level on a hardware request line. It then moves one unit per trigger (cycle-steal mode) or the whole count in one run (burst mode).

The engine owns the bus. Each unit takes one read cycle at the source and then one write cycle at the destination. Read data is returned combinationally in the read cycle. When both channels are waiting, a selectable policy picks the winner: fixed priority or round-robin. When a channel's count runs out, the channel disarms itself and raises a sticky done flag. The flag stays set until software clears it.

Top module: `dual_dma`

## Requirements
- R1: While reset is asserted and right after it, there is no bus activity. Every bus output is zero and both busy and done flags are low.
- R2: A pulse on `arm[c]` while channel c is not busy loads that channel's configuration and sets `ch_busy[c]`. An `arm[c]` pulse while the channel is busy is ignored and leaves the running transfer unchanged.
- R3: Each unit is one cycle with `bus_rd` high at the source address, followed in the next cycle by one cycle with `bus_wr` high at the destination address. In the write cycle, `bus_wdata` carries the data read in the read cycle. Read and write are never high together, and `bus_ch` names the channel that owns both cycles.
- R4: Size code 0 is 8-bit, 1 is 16-bit, and 2 or 3 are 32-bit. After each unit, both addresses advance by 1, 2 or 4 bytes. `bus_size` shows the code during bus cycles. Written data keeps only the low 8, 16 or 32 bits of the read data, and all other bits are zero.
- R5: The count is a 16-bit field. A value of 0 means 65,536 units.
- R6: In cycle-steal mode, one trigger moves exactly one unit. The bus then returns to idle for at least one cycle, and arbitration runs again before the next unit.
- R7: In burst mode, one trigger moves the whole count back to back: a write is followed directly by the next read, with no idle cycle. The other channel waits until the burst ends.
- R8: A channel armed for software trigger counts a pulse on `sw_req[c]` as a pending request. A channel armed for hardware trigger uses the level of `hw_req[c]` and ignores `sw_req[c]`.
- R9: With `arb_rr` low, channel 0 wins whenever both channels request in the same idle cycle.
- R10: With `arb_rr` high, when both channels request, the channel that did not win the previous grant wins. After reset, the previous winner counts as channel 1.
- R11: After the last unit's write cycle, `ch_busy[c]` falls and `ch_done[c]` rises in the same cycle. `ch_done[c]` stays set until a `done_clr[c]` pulse clears it. If the clear and a new completion happen in the same cycle, the completion wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arb_rr | input | 1 | 1 = round-robin arbitration, 0 = channel 0 first |
| arm | input | 2 | Per-channel pulse that loads the configuration |
| cfg_src | input | 2 x AW | Source start address per channel |
| cfg_dst | input | 2 x AW | Destination start address per channel |
| cfg_cnt | input | 2 x CW | Unit count per channel (0 = 65,536) |
| cfg_size | input | 2 x 2 | Unit width code per channel |
| cfg_burst | input | 2 | 1 = burst mode, 0 = cycle-steal mode |
| cfg_hw | input | 2 | 1 = hardware trigger, 0 = software trigger |
| sw_req | input | 2 | Software request pulses |
| hw_req | input | 2 | Hardware request levels |
| done_clr | input | 2 | Pulse that clears the done flag |
| bus_rd | output | 1 | Read cycle strobe |
| bus_wr | output | 1 | Write cycle strobe |
| bus_addr | output | AW | Byte address of the current bus cycle |
| bus_size | output | 2 | Unit width code of the current bus cycle |
| bus_wdata | output | 32 | Write data, right-aligned |
| bus_rdata | input | 32 | Read data, right-aligned, valid in the read cycle |
| bus_ch | output | 1 | Channel that owns the current bus cycle |
| ch_busy | output | 2 | Channel armed and not yet finished |
| ch_done | output | 2 | Sticky completion flags |

## Verification
The assertions check the bus on every cycle:
- read and write never overlap;
- every read is followed by a write from the same channel;
- every write is preceded by a read;
- written data never carries bits beyond the unit width;
- a done flag rises exactly when its channel's busy flag falls.

Some behaviour only the bench scenarios can show, because it depends on the order of requests and grants: which channel wins under each policy, whether cycle-steal releases the bus between units while burst keeps it, whether ignored arm and software pulses truly leave a transfer alone, and the 65,536-unit case. The bench covers these with a cycle-level reference model and ordered write logs.

// File: rtl/dual_dma_pkg.sv
package dual_dma_pkg;

    localparam int NCH    = 2;
    localparam int UNIT_W = 32;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_WR   = 2'd2
    } dma_state_e;

    // Byte stride for a unit width code; code 3 behaves as 32-bit.
    function automatic logic [2:0] unit_bytes(input logic [1:0] code);
        case (code)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic [UNIT_W-1:0] unit_mask(input logic [1:0] code);
        case (code)
            2'd0:    return 32'h0000_00FF;
            2'd1:    return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/dual_dma_arb.sv
module dual_dma_arb
    import dual_dma_pkg::*;
(
    input  logic [NCH-1:0] elig,
    input  logic           rr_mode,
    input  logic           last_win,
    output logic           any,
    output logic           win
);

    always_comb begin
        any = |elig;
        if (rr_mode && elig[0] && elig[1]) begin
            win = ~last_win;
        end else begin
            win = ~elig[0];
        end
    end

endmodule

// File: rtl/dual_dma_chan.sv
module dual_dma_chan
    import dual_dma_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
)
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm,
    input  logic [AW-1:0] cfg_src,
    input  logic [AW-1:0] cfg_dst,
    input  logic [CW-1:0] cfg_cnt,
    input  logic [1:0]    cfg_size,
    input  logic          cfg_burst,
    input  logic          cfg_hw,
    input  logic          sw_req,
    input  logic          hw_req,
    input  logic          done_clr,
    input  logic          take,
    input  logic          step,
    output logic          elig,
    output logic [AW-1:0] src,
    output logic [AW-1:0] dst,
    output logic [1:0]    size,
    output logic          burst,
    output logic          last,
    output logic          busy,
    output logic          done
);

    typedef struct packed {
        logic          en;
        logic          done;
        logic          pend;
        logic          hw;
        logic          burst;
        logic [1:0]    size;
        logic [CW-1:0] cnt;
        logic [AW-1:0] src;
        logic [AW-1:0] dst;
    } chan_t;

    chan_t q, d;
    logic [AW-1:0] stride;

    assign stride = AW'(unit_bytes(q.size));
    assign last   = (q.cnt == CW'(1));

    always_comb begin
        d = q;
        if (!q.en && arm) begin
            d.en    = 1'b1;
            d.pend  = 1'b0;
            d.hw    = cfg_hw;
            d.burst = cfg_burst;
            d.size  = cfg_size;
            d.cnt   = cfg_cnt;
            d.src   = cfg_src;
            d.dst   = cfg_dst;
        end
        if (take) begin
            d.pend = 1'b0;
        end
        if (sw_req && q.en && !q.hw) begin
            d.pend = 1'b1;
        end
        if (step) begin
            d.src = q.src + stride;
            d.dst = q.dst + stride;
            d.cnt = q.cnt - CW'(1);
            if (last) begin
                d.en   = 1'b0;
                d.pend = 1'b0;
            end
        end
        if (done_clr) begin
            d.done = 1'b0;
        end
        if (step && last) begin
            d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign elig  = q.en & (q.hw ? hw_req : q.pend);
    assign src   = q.src;
    assign dst   = q.dst;
    assign size  = q.size;
    assign burst = q.burst;
    assign busy  = q.en;
    assign done  = q.done;

endmodule

// File: rtl/dual_dma.sv
module dual_dma
    import dual_dma_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
)
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     arb_rr,
    input  logic [NCH-1:0]           arm,
    input  logic [NCH-1:0][AW-1:0]   cfg_src,
    input  logic [NCH-1:0][AW-1:0]   cfg_dst,
    input  logic [NCH-1:0][CW-1:0]   cfg_cnt,
    input  logic [NCH-1:0][1:0]      cfg_size,
    input  logic [NCH-1:0]           cfg_burst,
    input  logic [NCH-1:0]           cfg_hw,
    input  logic [NCH-1:0]           sw_req,
    input  logic [NCH-1:0]           hw_req,
    input  logic [NCH-1:0]           done_clr,
    output logic                     bus_rd,
    output logic                     bus_wr,
    output logic [AW-1:0]            bus_addr,
    output logic [1:0]               bus_size,
    output logic [UNIT_W-1:0]        bus_wdata,
    input  logic [UNIT_W-1:0]        bus_rdata,
    output logic                     bus_ch,
    output logic [NCH-1:0]           ch_busy,
    output logic [NCH-1:0]           ch_done
);

    typedef struct packed {
        dma_state_e        state;
        logic              gnt;
        logic              lastw;
        logic [UNIT_W-1:0] data;
    } core_t;

    core_t q, d;

    logic [NCH-1:0]         take, step, elig, burst_w, last_w;
    logic [NCH-1:0][AW-1:0] src_w, dst_w;
    logic [NCH-1:0][1:0]    size_w;
    logic                   any_req, winner;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        dual_dma_chan #(.AW(AW), .CW(CW)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .arm      (arm[c]),
            .cfg_src  (cfg_src[c]),
            .cfg_dst  (cfg_dst[c]),
            .cfg_cnt  (cfg_cnt[c]),
            .cfg_size (cfg_size[c]),
            .cfg_burst(cfg_burst[c]),
            .cfg_hw   (cfg_hw[c]),
            .sw_req   (sw_req[c]),
            .hw_req   (hw_req[c]),
            .done_clr (done_clr[c]),
            .take     (take[c]),
            .step     (step[c]),
            .elig     (elig[c]),
            .src      (src_w[c]),
            .dst      (dst_w[c]),
            .size     (size_w[c]),
            .burst    (burst_w[c]),
            .last     (last_w[c]),
            .busy     (ch_busy[c]),
            .done     (ch_done[c])
        );
    end

    dual_dma_arb u_arb (
        .elig    (elig),
        .rr_mode (arb_rr),
        .last_win(q.lastw),
        .any     (any_req),
        .win     (winner)
    );

    // Sequencer: idle (arbitrate) -> read -> write -> idle or read.
    always_comb begin
        d    = q;
        take = '0;
        step = '0;
        case (q.state)
            ST_IDLE: begin
                if (any_req) begin
                    d.gnt        = winner;
                    d.lastw      = winner;
                    d.state      = ST_RD;
                    take[winner] = 1'b1;
                end
            end
            ST_RD: begin
                d.data  = bus_rdata & unit_mask(size_w[q.gnt]);
                d.state = ST_WR;
            end
            ST_WR: begin
                step[q.gnt] = 1'b1;
                d.state = (last_w[q.gnt] || !burst_w[q.gnt]) ? ST_IDLE : ST_RD;
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: ST_IDLE, gnt: 1'b0, lastw: 1'b1, data: '0};
        end else begin
            q <= d;
        end
    end

    always_comb begin
        bus_rd    = (q.state == ST_RD);
        bus_wr    = (q.state == ST_WR);
        bus_ch    = (bus_rd || bus_wr) ? q.gnt : 1'b0;
        bus_size  = (bus_rd || bus_wr) ? size_w[q.gnt] : 2'd0;
        bus_wdata = bus_wr ? q.data : '0;
        if (bus_rd) begin
            bus_addr = src_w[q.gnt];
        end else if (bus_wr) begin
            bus_addr = dst_w[q.gnt];
        end else begin
            bus_addr = '0;
        end
    end

endmodule

// File: rtl/dual_dma_chk.sv
module dual_dma_chk
    import dual_dma_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [1:0]        bus_size,
    input logic [UNIT_W-1:0] bus_wdata,
    input logic              bus_ch,
    input logic [NCH-1:0]    ch_busy,
    input logic [NCH-1:0]    ch_done
);

    assert_rd_wr_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr))
        else $error("read and write strobes overlap");

    assert_rd_then_wr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> (bus_wr && bus_ch == $past(bus_ch)))
        else $error("read not followed by write of same channel");

    assert_wr_after_rd_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |-> $past(bus_rd))
        else $error("write without preceding read");

    assert_unit_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |-> ((bus_wdata & ~unit_mask(bus_size)) == '0))
        else $error("write data exceeds unit width");

    for (genvar c = 0; c < NCH; c++) begin : g_chk
        assert_done_rise_R11: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ch_done[c]) |-> $fell(ch_busy[c]))
            else $error("done rose without busy falling");

        assert_busy_fall_R11: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(ch_busy[c]) |-> ch_done[c])
            else $error("busy fell without done");
    end

endmodule

bind dual_dma dual_dma_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_rd   (bus_rd),
    .bus_wr   (bus_wr),
    .bus_size (bus_size),
    .bus_wdata(bus_wdata),
    .bus_ch   (bus_ch),
    .ch_busy  (ch_busy),
    .ch_done  (ch_done)
);

// File: tb/dual_dma_test.sv
`timescale 1ns/1ps
module dual_dma_test;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              arb_rr = 1'b0;
    logic [1:0]        arm = '0;
    logic [1:0][31:0]  cfg_src = '0;
    logic [1:0][31:0]  cfg_dst = '0;
    logic [1:0][15:0]  cfg_cnt = '0;
    logic [1:0][1:0]   cfg_size = '0;
    logic [1:0]        cfg_burst = '0;
    logic [1:0]        cfg_hw = '0;
    logic [1:0]        sw_req = '0;
    logic [1:0]        hw_req = '0;
    logic [1:0]        done_clr = '0;
    logic              bus_rd, bus_wr, bus_ch;
    logic [31:0]       bus_addr, bus_wdata, bus_rdata;
    logic [1:0]        bus_size, ch_busy, ch_done;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    function automatic logic [31:0] rdfn(input logic [31:0] a);
        return {~a[15:0], a[15:0]} ^ 32'h3C5A_96E1;
    endfunction

    function automatic int stride(input int s);
        return (s == 0) ? 1 : (s == 1) ? 2 : 4;
    endfunction

    function automatic logic [31:0] mask(input int s);
        return (s == 0) ? 32'hFF : (s == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
    endfunction

    assign bus_rdata = rdfn(bus_addr);

    dual_dma uut (
        .clk(clk), .rst_n(rst_n), .arb_rr(arb_rr), .arm(arm),
        .cfg_src(cfg_src), .cfg_dst(cfg_dst), .cfg_cnt(cfg_cnt),
        .cfg_size(cfg_size), .cfg_burst(cfg_burst), .cfg_hw(cfg_hw),
        .sw_req(sw_req), .hw_req(hw_req), .done_clr(done_clr),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ch(bus_ch), .ch_busy(ch_busy), .ch_done(ch_done)
    );

    // ---------------- behavioural reference model ----------------
    bit          m_en[2], m_done[2], m_pend[2], m_hw[2], m_burst[2];
    int          m_size[2], m_rem[2];
    logic [31:0] m_src[2], m_dst[2];
    int          m_state = 0, m_g = 0, m_last = 1;
    logic [31:0] m_data = '0;

    task automatic model_reset();
        for (int i = 0; i < 2; i++) begin
            m_en[i] = 0; m_done[i] = 0; m_pend[i] = 0; m_hw[i] = 0;
            m_burst[i] = 0; m_size[i] = 0; m_rem[i] = 0;
            m_src[i] = '0; m_dst[i] = '0;
        end
        m_state = 0; m_g = 0; m_last = 1; m_data = '0;
    endtask

    task automatic model_step();
        bit el[2], tk[2], st[2], en_old;
        int w;
        for (int i = 0; i < 2; i++) begin
            el[i] = m_en[i] && (m_hw[i] ? hw_req[i] : m_pend[i]);
            tk[i] = 0; st[i] = 0;
        end
        case (m_state)
            0: if (el[0] || el[1]) begin
                if (el[0] && el[1]) w = arb_rr ? 1 - m_last : 0;
                else w = el[0] ? 0 : 1;
                m_g = w; m_last = w; m_state = 1; tk[w] = 1;
            end
            1: begin
                m_data = rdfn(m_src[m_g]) & mask(m_size[m_g]);
                m_state = 2;
            end
            default: begin
                st[m_g] = 1;
                m_state = (m_rem[m_g] == 1 || !m_burst[m_g]) ? 0 : 1;
            end
        endcase
        for (int i = 0; i < 2; i++) begin
            en_old = m_en[i];
            if (!m_en[i] && arm[i]) begin
                m_en[i] = 1; m_pend[i] = 0; m_hw[i] = cfg_hw[i];
                m_burst[i] = cfg_burst[i]; m_size[i] = int'(cfg_size[i]);
                m_rem[i] = (cfg_cnt[i] == 0) ? 65536 : int'(cfg_cnt[i]);
                m_src[i] = cfg_src[i]; m_dst[i] = cfg_dst[i];
            end
            if (tk[i]) m_pend[i] = 0;
            if (sw_req[i] && en_old && !m_hw[i]) m_pend[i] = 1;
            if (done_clr[i]) m_done[i] = 0;
            if (st[i]) begin
                m_src[i] = m_src[i] + stride(m_size[i]);
                m_dst[i] = m_dst[i] + stride(m_size[i]);
                if (m_rem[i] == 1) begin
                    m_en[i] = 0; m_pend[i] = 0; m_done[i] = 1;
                end
                m_rem[i] = m_rem[i] - 1;
            end
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) model_reset();
        else model_step();
    end

    // ---------------- checking ----------------
    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    int          cyc_n = 0;
    int          wr_cnt[2];
    int          first_wr_cyc[2], last_wr_cyc[2];
    logic [31:0] first_wr_addr[2], last_wr_addr[2];
    bit          seen[2];
    int          order[$];

    task automatic clear_track();
        for (int i = 0; i < 2; i++) begin
            wr_cnt[i] = 0; seen[i] = 0;
        end
        order.delete();
    endtask

    always @(negedge clk) begin
        bit act;
        logic [31:0] ea;
        cyc_n++;
        act = (m_state != 0);
        ea  = (m_state == 1) ? m_src[m_g] : (m_state == 2) ? m_dst[m_g] : 32'h0;
        chk("R3 bus_rd", bus_rd, m_state == 1);
        chk("R3 bus_wr", bus_wr, m_state == 2);
        chk("R3 bus_addr", bus_addr, ea);
        chk("R3 bus_ch", bus_ch, act ? m_g : 0);
        chk("R4 bus_size", bus_size, act ? m_size[m_g] : 0);
        chk("R4 bus_wdata", bus_wdata, (m_state == 2) ? m_data : 32'h0);
        chk("R2 ch_busy", ch_busy, {m_en[1], m_en[0]});
        chk("R11 ch_done", ch_done, {m_done[1], m_done[0]});
        if (rst_n && bus_wr) begin
            wr_cnt[bus_ch]++;
            order.push_back(int'(bus_ch));
            if (!seen[bus_ch]) begin
                seen[bus_ch] = 1;
                first_wr_cyc[bus_ch] = cyc_n;
                first_wr_addr[bus_ch] = bus_addr;
            end
            last_wr_cyc[bus_ch] = cyc_n;
            last_wr_addr[bus_ch] = bus_addr;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic arm_ch(input int c, input logic [31:0] s, input logic [31:0] t,
                          input int cnt, input int sz, input bit b, input bit h);
        @(negedge clk);
        cfg_src[c] = s; cfg_dst[c] = t; cfg_cnt[c] = 16'(cnt);
        cfg_size[c] = 2'(sz); cfg_burst[c] = b; cfg_hw[c] = h; arm[c] = 1'b1;
        @(negedge clk);
        arm[c] = 1'b0;
    endtask

    task automatic pulse_sw(input int c);
        @(negedge clk); sw_req[c] = 1'b1;
        @(negedge clk); sw_req[c] = 1'b0;
    endtask

    task automatic clr_done(input logic [1:0] m);
        @(negedge clk); done_clr = m;
        @(negedge clk); done_clr = '0;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        int n;
        clear_track();
        cyc(4);
        // R1: quiet reset state
        chk("R1 rd", bus_rd, 0); chk("R1 wr", bus_wr, 0);
        chk("R1 addr", bus_addr, 0); chk("R1 busy", ch_busy, 0);
        chk("R1 done", ch_done, 0);
        rst_n = 1'b1;
        cyc(2);
        chk("R1 idle after reset", bus_rd | bus_wr, 0);

        // R6/R8: software cycle-steal, 32-bit units
        arm_ch(0, 32'h100, 32'h200, 3, 2, 0, 0);
        chk("R2 busy after arm", ch_busy[0], 1);
        pulse_sw(0); cyc(8);
        chk("R6 one unit per trigger", wr_cnt[0], 1);
        pulse_sw(0); cyc(6); pulse_sw(0); cyc(8);
        chk("R6 three triggers", wr_cnt[0], 3);
        chk("R4 last dst word", last_wr_addr[0], 32'h208);
        chk("R11 done set", ch_done[0], 1);
        cyc(10);
        chk("R11 done sticky", ch_done[0], 1);
        clr_done(2'b01); cyc(1);
        chk("R11 done cleared", ch_done[0], 0);

        // R8/R7: hardware-triggered burst, 8-bit units
        clear_track();
        arm_ch(1, 32'h400, 32'h800, 5, 0, 1, 1);
        pulse_sw(1); cyc(6);
        chk("R8 sw ignored on hw channel", wr_cnt[1], 0);
        @(negedge clk); hw_req[1] = 1'b1;
        @(negedge clk); hw_req[1] = 1'b0;
        cyc(20);
        chk("R7 burst count", wr_cnt[1], 5);
        chk("R7 back to back", last_wr_cyc[1] - first_wr_cyc[1], 8);
        chk("R4 byte stride", last_wr_addr[1], 32'h804);

        // R2: re-arm while busy ignored, 16-bit units
        clear_track();
        arm_ch(0, 32'h1000, 32'h2000, 2, 1, 0, 1);
        arm_ch(0, 32'h5000, 32'h6000, 7, 0, 1, 0);
        @(negedge clk); hw_req[0] = 1'b1;
        cyc(12); hw_req[0] = 1'b0;
        chk("R2 count kept", wr_cnt[0], 2);
        chk("R2 first dst kept", first_wr_addr[0], 32'h2000);
        chk("R4 halfword stride", last_wr_addr[0], 32'h2002);

        // R4: code 3 behaves as 32-bit
        clear_track();
        arm_ch(1, 32'h40, 32'h80, 2, 3, 1, 0);
        pulse_sw(1); cyc(10);
        chk("R4 code3 stride", last_wr_addr[1], 32'h84);
        clr_done(2'b11);

        // R9: fixed priority
        clear_track();
        arb_rr = 1'b0;
        arm_ch(0, 32'h0, 32'h100, 3, 2, 0, 1);
        arm_ch(1, 32'h300, 32'h400, 3, 2, 0, 1);
        @(negedge clk); hw_req = 2'b11;
        cyc(30); hw_req = 2'b00;
        chk("R9 unit count", order.size(), 6);
        for (int i = 0; i < 6; i++)
            if (i < order.size()) chk("R9 grant order", order[i], (i < 3) ? 0 : 1);

        // R10: round-robin, previous winner was channel 1
        clear_track();
        arb_rr = 1'b1;
        arm_ch(0, 32'h0, 32'h100, 3, 2, 0, 1);
        arm_ch(1, 32'h300, 32'h400, 3, 2, 0, 1);
        @(negedge clk); hw_req = 2'b11;
        cyc(30); hw_req = 2'b00;
        chk("R10 unit count", order.size(), 6);
        for (int i = 0; i < 6; i++)
            if (i < order.size()) chk("R10 alternation", order[i], i % 2);
        clr_done(2'b11);

        // R7: burst holds the bus against the other channel
        clear_track();
        arb_rr = 1'b0;
        arm_ch(1, 32'h900, 32'hA00, 4, 2, 1, 0);
        arm_ch(0, 32'hB00, 32'hC00, 1, 2, 0, 0);
        pulse_sw(1); pulse_sw(0); cyc(20);
        chk("R7 burst order len", order.size(), 5);
        for (int i = 0; i < 5; i++)
            if (i < order.size()) chk("R7 burst blocks", order[i], (i < 4) ? 1 : 0);
        clr_done(2'b11);

        // R5: count 0 means 65536 units
        clear_track();
        arm_ch(0, 32'h0, 32'h10_0000, 0, 0, 1, 0);
        pulse_sw(0);
        n = 0;
        while (!ch_done[0] && n < 140000) begin
            @(negedge clk); n++;
        end
        chk("R5 full count", wr_cnt[0], 65536);
        chk("R5 last dst", last_wr_addr[0], 32'h10_FFFF);
        cyc(4);
        finish_run();
    end

endmodule